// File: doc/BRIEF.md
# SPI Status and Interrupt Flag Unit

This block collects the event pulses and receive/transmit FIFO levels that an SPI datapath produces and keeps them as status for software. Eight events are held in sticky flags that software clears by writing ones. Ten enable bits select which conditions may raise the single interrupt request. The block also owns the peripheral-enable bit and the I/O-lock bit, and the rules that tie them to a mode fault.

The flags and enables affect one another. When the last frame of a transfer has been loaded, the transmit-space and duplex interrupt enables turn off by themselves. One enable bit covers three completion-type conditions. The transmit-complete bit means one thing for an endless transfer and another for a counted one. A mode fault forces the peripheral off and holds it off until software clears the fault.

Software reaches the block through a word-wide register port with a single-cycle write strobe and a combinational read. The shifter, the FIFOs and the CRC engine are outside this block. They supply the event pulses and level signals.

Top module: `spi_flag_unit`

Register map (word addresses on `reg_addr`):

| Address | Register | Contents |
|---|---|---|
| 0 | control | bit 0 peripheral enable, bit 1 I/O lock |
| 1 | interrupt enable | bits 9:0, as listed in R8 |
| 2 | status | read-only; bit positions in R1, R2, R5 and R10 |
| 3 | clear | write-only; reads as zero |
| 4 | transfer length | low 16 bits |

Addresses 5 to 7 read as zero.

## Requirements
- R1: Status bit 0 shows `rx_pkt_avail` and bit 1 shows `tx_space_avail`. Status bit 2 (duplex ready) is 1 exactly when both of those are 1.
- R2: A pulse on `ev_set[k]` sets sticky status bit k+3. The event order is: 0 end-of-transfer, 1 transmit-filled, 2 underrun, 3 overrun, 4 CRC error, 5 frame error, 6 mode fault, 7 suspend. Writing 1 to bit k+3 of the clear register (address 3) clears that flag. Writing 0 leaves it unchanged.
- R3: If a set pulse and a clearing write reach the same flag in the same cycle, the flag ends up set.
- R4: A transmit-filled event (`ev_set[1]`) clears interrupt-enable bits 1 and 2 at the same clock edge. This also overrides a write to the enable register in that cycle. All other enable bits keep their values.
- R5: Status bit 11 (transmit complete) depends on the transfer length. When the length is 0, it equals `txfifo_empty` AND `bus_idle`. When the length is nonzero, it equals the end-of-transfer flag, including after software clears that flag.
- R6: A mode-fault event clears the peripheral enable and the I/O lock at the next edge. While the mode-fault flag is set, neither bit can be set by a write.
- R7: A write to the I/O-lock bit (control bit 1) takes effect only while the peripheral is disabled. The lock clears on the same edge at which the enable changes from 1 to 0.
- R8: `irq` is a registered copy, one cycle late, of the OR over each source ANDed with its enable. The enable bits are: 0 rx-packet, 1 tx-space, 2 duplex, 3 the shared group of end-of-transfer, suspend and transmit-complete, 4 transmit-filled, 5 underrun, 6 overrun, 7 CRC error, 8 frame error, 9 mode fault.
- R9: While the peripheral is disabled, only an enabled mode-fault flag can raise `irq`.
- R10: Status bits 13:12 show `rx_level` (0 to 3 residual frames). Status bit 14 shows `rx_word_full` (at least four bytes occupied).
- R11: After reset, the enables, the flags, the length, the peripheral enable, the I/O lock and `irq` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| ev_set | input | 8 | One-cycle event pulses, ordered as in R2 |
| rx_pkt_avail | input | 1 | Receive FIFO holds at least one packet |
| tx_space_avail | input | 1 | Transmit FIFO has room for one packet |
| txfifo_empty | input | 1 | Transmit FIFO is empty |
| bus_idle | input | 1 | No frame is in progress on the bus |
| rx_level | input | 2 | Residual receive frame count |
| rx_word_full | input | 1 | At least four bytes are held in the receive FIFO |
| periph_en | output | 1 | Peripheral enable bit |
| io_lock | output | 1 | I/O lock bit |
| irq | output | 1 | Interrupt request |

## Verification
A flag or enable stored wrongly shows up on the same cycle in a read of the status or enable register. It also shows up on `irq` one edge later, provided the matching enable is set. An error in the enable or lock logic appears at `periph_en` and `io_lock` right after the edge that caused it. The bench keeps its own model of every register, and on every cycle it compares the model with the read port, the interrupt and the two control outputs. A fault is therefore caught in the cycle it first reaches a port, not at the end of a scenario.

// File: rtl/spi_flag_pkg.sv
// Package: shared register addresses, bit positions and sizes of the SPI
// status and interrupt flag unit. Assumes a 32-bit register port.
package spi_flag_pkg;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 3;
    localparam int LEN_W   = 16;

    // Register word addresses
    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_IEN  = 3'd1;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd2;
    localparam logic [ADDR_W-1:0] A_CLR  = 3'd3;
    localparam logic [ADDR_W-1:0] A_LEN  = 3'd4;

    // Sticky events; event k lives at status / clear bit EV_BASE+k
    localparam int N_EV    = 8;
    localparam int EV_BASE = 3;
    localparam int EV_EOT  = 0;
    localparam int EV_TXTF = 1;
    localparam int EV_MODF = 6;
    localparam int EV_SUSP = 7;

    // Interrupt enable bits
    localparam int N_IE    = 10;
    localparam int IE_RXP  = 0;
    localparam int IE_TXP  = 1;
    localparam int IE_DXP  = 2;
    localparam int IE_DONE = 3;
    localparam int IE_STK0 = 4;   // enables 4..9 map to sticky events 1..6
    localparam int IE_MODF = 9;

    // Status bits outside the sticky range
    localparam int ST_RXP  = 0;
    localparam int ST_TXP  = 1;
    localparam int ST_DXP  = 2;
    localparam int ST_TXC  = EV_BASE + N_EV;  // 11
    localparam int ST_LVL  = 12;              // 2-bit field 13:12
    localparam int ST_WORD = 14;
endpackage

// File: rtl/spi_sticky_bank.sv
// Module: bank of N sticky flags. A set pulse raises a flag and a clear
// request drops it. Set wins when both arrive in the same cycle.
// Assumes set pulses come from the datapath and clears from a register write.
module spi_sticky_bank #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);
    logic [N-1:0] flag_q;

    for (genvar i = 0; i < N; i++) begin : g_flag
        // Hold one flag, giving the set event priority over the clear
        always_ff @(posedge clk) begin
            if (!rst_n)        flag_q[i] <= 1'b0;
            else if (set_i[i]) flag_q[i] <= 1'b1;
            else if (clr_i[i]) flag_q[i] <= 1'b0;
        end

        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> flag_o[i]);                               // R3
        AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[i] && !set_i[i]) |=> !flag_o[i]);               // R2
        AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_i[i] && !set_i[i]) |=> $stable(flag_o[i]));      // R2
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/spi_enable_lock.sv
// Module: owns the peripheral enable bit and the I/O lock bit.
// A mode fault clears both and blocks setting them while its flag stays up.
// The lock is writable only while disabled and drops when enable falls.
// Assumes fault_flag_i is the current (registered) mode-fault flag.
module spi_enable_lock (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_i,
    input  logic wen_i,
    input  logic wlock_i,
    input  logic fault_ev_i,
    input  logic fault_flag_i,
    output logic en_o,
    output logic lock_o
);
    logic en_q, lock_q;
    logic en_n, lock_n;

    // Next-state rules for enable and lock, fault taking final priority
    always_comb begin
        en_n   = en_q;
        lock_n = lock_q;
        if (wr_i) begin
            en_n = wen_i & ~fault_flag_i;
            if (!en_q && !fault_flag_i) lock_n = wlock_i;
        end
        if (fault_ev_i) begin
            en_n   = 1'b0;
            lock_n = 1'b0;
        end
        if (en_q && !en_n) lock_n = 1'b0;
    end

    // Register enable and lock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            lock_q <= 1'b0;
        end else begin
            en_q   <= en_n;
            lock_q <= lock_n;
        end
    end

    assign en_o   = en_q;
    assign lock_o = lock_q;

    AST_FAULT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        fault_ev_i |=> (!en_o && !lock_o));                        // R6
    AST_FAULT_HOLDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        fault_flag_i |-> (!en_o && !lock_o));                      // R6
    AST_LOCK_WHILE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_o) |-> !$past(en_o));                           // R7
    AST_LOCK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en_o) |-> !lock_o);                                  // R7
endmodule

// File: rtl/spi_irq_merge.sv
// Module: combines interrupt sources with their enables into one registered
// request. While the peripheral is disabled only the mode-fault source passes.
// Assumes src_i and ien_i share the same bit order.
module spi_irq_merge #(
    parameter int N       = 10,
    parameter int FAULT_I = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src_i,
    input  logic [N-1:0] ien_i,
    input  logic         en_i,
    output logic         irq_o
);
    localparam logic [N-1:0] FAULT_ONLY = N'(1) << FAULT_I;

    logic [N-1:0] pass_mask;
    logic         pend;
    logic         irq_q;

    // Select which sources may pass and OR the enabled ones
    always_comb begin
        pass_mask = en_i ? '1 : FAULT_ONLY;
        pend      = |(src_i & ien_i & pass_mask);
    end

    // Register the request
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= pend;
    end

    assign irq_o = irq_q;

    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && |(src_i & ien_i)) |=> irq_o);                     // R8
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (~|(src_i & ien_i)) |=> !irq_o);                           // R8
    AST_IRQ_OFF_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !(src_i[FAULT_I] && ien_i[FAULT_I])) |=> !irq_o); // R9
endmodule

// File: rtl/spi_flag_unit.sv
// Module: top of the SPI status and interrupt flag unit. Decodes the register
// port, keeps the enable and length registers, builds the status word and
// wires the sticky bank, the enable/lock logic and the interrupt merger.
// Assumes single-cycle write strobes and event pulses one cycle wide.
module spi_flag_unit
    import spi_flag_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [N_EV-1:0]   ev_set,
    input  logic              rx_pkt_avail,
    input  logic              tx_space_avail,
    input  logic              txfifo_empty,
    input  logic              bus_idle,
    input  logic [1:0]        rx_level,
    input  logic              rx_word_full,
    output logic              periph_en,
    output logic              io_lock,
    output logic              irq
);
    localparam int N_STK_IE = IE_MODF - IE_STK0 + 1;

    logic [N_IE-1:0]   ien_q;
    logic [LEN_W-1:0]  len_q;
    logic [N_EV-1:0]   flags;
    logic [N_EV-1:0]   clr_req;
    logic [N_IE-1:0]   irq_src;
    logic [DATA_W-1:0] status;
    logic              dxp, txc;
    logic              wr_ctrl, wr_ien, wr_clr, wr_len;

    // Decode write strobes per register
    always_comb begin
        wr_ctrl = reg_wr && (reg_addr == A_CTRL);
        wr_ien  = reg_wr && (reg_addr == A_IEN);
        wr_clr  = reg_wr && (reg_addr == A_CLR);
        wr_len  = reg_wr && (reg_addr == A_LEN);
        clr_req = wr_clr ? reg_wdata[EV_BASE +: N_EV] : '0;
    end

    // Interrupt enables; transmit-filled event turns off tx and duplex enables
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q <= '0;
        end else begin
            if (wr_ien) ien_q <= reg_wdata[N_IE-1:0];
            if (ev_set[EV_TXTF]) begin
                ien_q[IE_TXP] <= 1'b0;
                ien_q[IE_DXP] <= 1'b0;
            end
        end
    end

    // Transfer length register
    always_ff @(posedge clk) begin
        if (!rst_n)      len_q <= '0;
        else if (wr_len) len_q <= reg_wdata[LEN_W-1:0];
    end

    spi_sticky_bank #(.N(N_EV)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (ev_set),
        .clr_i  (clr_req),
        .flag_o (flags)
    );

    spi_enable_lock u_enlock (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_i         (wr_ctrl),
        .wen_i        (reg_wdata[0]),
        .wlock_i      (reg_wdata[1]),
        .fault_ev_i   (ev_set[EV_MODF]),
        .fault_flag_i (flags[EV_MODF]),
        .en_o         (periph_en),
        .lock_o       (io_lock)
    );

    // Derived status: duplex ready and length-dependent transmit complete
    always_comb begin
        dxp = rx_pkt_avail & tx_space_avail;
        txc = (len_q == '0) ? (txfifo_empty & bus_idle) : flags[EV_EOT];
    end

    // Assemble the status word
    always_comb begin
        status                      = '0;
        status[ST_RXP]              = rx_pkt_avail;
        status[ST_TXP]              = tx_space_avail;
        status[ST_DXP]              = dxp;
        status[EV_BASE +: N_EV]     = flags;
        status[ST_TXC]              = txc;
        status[ST_LVL +: 2]         = rx_level;
        status[ST_WORD]             = rx_word_full;
    end

    // Interrupt sources in enable-bit order; the done group shares one enable
    always_comb begin
        irq_src                      = '0;
        irq_src[IE_RXP]              = rx_pkt_avail;
        irq_src[IE_TXP]              = tx_space_avail;
        irq_src[IE_DXP]              = dxp;
        irq_src[IE_DONE]             = flags[EV_EOT] | flags[EV_SUSP] | txc;
        irq_src[IE_STK0 +: N_STK_IE] = flags[EV_TXTF +: N_STK_IE];
    end

    spi_irq_merge #(.N(N_IE), .FAULT_I(IE_MODF)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .src_i (irq_src),
        .ien_i (ien_q),
        .en_i  (periph_en),
        .irq_o (irq)
    );

    // Read multiplexer
    always_comb begin
        unique case (reg_addr)
            A_CTRL:  reg_rdata = {{(DATA_W-2){1'b0}}, io_lock, periph_en};
            A_IEN:   reg_rdata = {{(DATA_W-N_IE){1'b0}}, ien_q};
            A_STAT:  reg_rdata = status;
            A_LEN:   reg_rdata = {{(DATA_W-LEN_W){1'b0}}, len_q};
            default: reg_rdata = '0;
        endcase
    end

    AST_TXTF_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_set[EV_TXTF] |=> (!ien_q[IE_TXP] && !ien_q[IE_DXP]));   // R4
    AST_FLAG_FROM_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        ev_set[EV_EOT] |=> status[EV_BASE + EV_EOT]);             // R2
endmodule

// File: tb/spi_flag_unit_tb_top.sv
// Bench: behavioural reference model compared with every port on every clock,
// plus directed scenarios for each requirement.
module spi_flag_unit_tb_top;
    localparam int CLK_P     = 10;
    localparam int MAX_CYC   = 100000;
    localparam int RAND_CYC  = 4000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr;
    logic [2:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [7:0]  ev_set;
    logic        rx_pkt_avail, tx_space_avail, txfifo_empty, bus_idle;
    logic [1:0]  rx_level;
    logic        rx_word_full;
    logic        periph_en, io_lock, irq;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;

    always #(CLK_P/2) clk = ~clk;

    spi_flag_unit dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_set(ev_set),
        .rx_pkt_avail(rx_pkt_avail), .tx_space_avail(tx_space_avail),
        .txfifo_empty(txfifo_empty), .bus_idle(bus_idle), .rx_level(rx_level),
        .rx_word_full(rx_word_full), .periph_en(periph_en), .io_lock(io_lock),
        .irq(irq)
    );

    // ---------------- reference model ----------------
    logic        m_en, m_lock, m_irq;
    logic [9:0]  m_ien;
    logic [7:0]  m_fl;
    logic [15:0] m_len;

    function automatic logic m_txc();
        return (m_len == 0) ? (txfifo_empty && bus_idle) : m_fl[0];
    endfunction

    function automatic logic [31:0] m_status();
        logic [31:0] s = 0;
        s[0] = rx_pkt_avail;
        s[1] = tx_space_avail;
        s[2] = rx_pkt_avail && tx_space_avail;
        for (int k = 0; k < 8; k++) s[3+k] = m_fl[k];
        s[11] = m_txc();
        s[13:12] = rx_level;
        s[14] = rx_word_full;
        return s;
    endfunction

    function automatic logic [31:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return {30'b0, m_lock, m_en};
            3'd1: return {22'b0, m_ien};
            3'd2: return m_status();
            3'd4: return {16'b0, m_len};
            default: return 32'b0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_lock = 0; m_irq = 0; m_ien = 0; m_fl = 0; m_len = 0;
        end else begin
            logic [9:0] src;
            logic       pend;
            logic       en_n, lock_n;
            src = 0;
            src[0] = rx_pkt_avail;
            src[1] = tx_space_avail;
            src[2] = rx_pkt_avail && tx_space_avail;
            src[3] = m_fl[0] || m_fl[7] || m_txc();
            for (int k = 1; k <= 6; k++) src[3+k] = m_fl[k];
            pend = 0;
            for (int b = 0; b < 10; b++)
                if (src[b] && m_ien[b] && (m_en || b == 9)) pend = 1;
            en_n = m_en; lock_n = m_lock;
            if (reg_wr && reg_addr == 3'd0) begin
                en_n = reg_wdata[0] && !m_fl[6];
                if (!m_en && !m_fl[6]) lock_n = reg_wdata[1];
            end
            if (ev_set[6]) begin en_n = 0; lock_n = 0; end
            if (m_en && !en_n) lock_n = 0;
            if (reg_wr && reg_addr == 3'd1) m_ien = reg_wdata[9:0];
            if (ev_set[1]) begin m_ien[1] = 0; m_ien[2] = 0; end
            if (reg_wr && reg_addr == 3'd4) m_len = reg_wdata[15:0];
            for (int k = 0; k < 8; k++) begin
                if (ev_set[k]) m_fl[k] = 1;
                else if (reg_wr && reg_addr == 3'd3 && reg_wdata[3+k]) m_fl[k] = 0;
            end
            m_en = en_n; m_lock = lock_n; m_irq = pend;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // Per-cycle comparison, a quarter period after the active edge
    always @(posedge clk) begin
        #(CLK_P/4);
        cycles++;
        if (rst_n && !done) begin
            chk("R8 irq", {31'b0, irq}, {31'b0, m_irq});
            chk("R6 periph_en", {31'b0, periph_en}, {31'b0, m_en});
            chk("R7 io_lock", {31'b0, io_lock}, {31'b0, m_lock});
            chk("R2 read port", reg_rdata, m_read(reg_addr));
        end
        if (cycles > MAX_CYC && !done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected < %0d cycles", cycles, MAX_CYC);
            finish_run();
        end
    end

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic pulse(input int k);
        @(negedge clk);
        ev_set = 8'b1 << k;
        @(negedge clk);
        ev_set = 0;
    endtask

    function automatic logic [31:0] rd_now(input logic [2:0] a);
        return 32'b0;
    endfunction

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    initial begin
        logic [31:0] v;
        rst_n = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0; ev_set = 0;
        rx_pkt_avail = 0; tx_space_avail = 0; txfifo_empty = 0; bus_idle = 0;
        rx_level = 0; rx_word_full = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R11 reset state
        rd(3'd0, v); chk("R11 control", v, 0);
        rd(3'd1, v); chk("R11 enables", v, 0);
        rd(3'd2, v); chk("R11 status", v, 0);
        rd(3'd4, v); chk("R11 length", v, 0);
        chk("R11 irq", {31'b0, irq}, 0);

        // R1 duplex flag
        @(negedge clk); rx_pkt_avail = 1; tx_space_avail = 1;
        rd(3'd2, v); chk("R1 duplex both", {29'b0, v[2:0]}, 32'h7);
        tx_space_avail = 0;
        rd(3'd2, v); chk("R1 duplex rx only", {29'b0, v[2:0]}, 32'h1);
        rx_pkt_avail = 0; tx_space_avail = 1;
        rd(3'd2, v); chk("R1 duplex tx only", {29'b0, v[2:0]}, 32'h2);
        tx_space_avail = 0;

        // R10 receive level pass-through
        rx_level = 2'd3; rx_word_full = 1;
        rd(3'd2, v); chk("R10 level/word", {29'b0, v[14:12]}, 32'h7);
        rx_level = 2'd2; rx_word_full = 0;
        rd(3'd2, v); chk("R10 level 2", {29'b0, v[14:12]}, 32'h2);
        rx_level = 0;

        // R2 sticky set, zero write, one write
        pulse(2);
        rd(3'd2, v); chk("R2 underrun set", {31'b0, v[5]}, 1);
        wr(3'd3, 32'h0);
        rd(3'd2, v); chk("R2 zero write keeps", {31'b0, v[5]}, 1);
        wr(3'd3, 32'h20);
        rd(3'd2, v); chk("R2 one write clears", {31'b0, v[5]}, 0);

        // R3 set wins over clear
        @(negedge clk);
        ev_set = 8'h08; reg_wr = 1; reg_addr = 3'd3; reg_wdata = 32'h40;
        @(negedge clk);
        ev_set = 0; reg_wr = 0;
        rd(3'd2, v); chk("R3 overrun set wins", {31'b0, v[6]}, 1);
        wr(3'd3, 32'h40);

        // R4 transmit-filled clears tx/duplex enables
        wr(3'd1, 32'h3FF);
        pulse(1);
        rd(3'd1, v); chk("R4 enables after fill", v, 32'h3F9);
        @(negedge clk);
        ev_set = 8'h02; reg_wr = 1; reg_addr = 3'd1; reg_wdata = 32'h006;
        @(negedge clk);
        ev_set = 0; reg_wr = 0;
        rd(3'd1, v); chk("R4 fill beats write", v, 32'h0);
        wr(3'd3, 32'h7F8);

        // R5 transmit complete in both length modes
        txfifo_empty = 1; bus_idle = 1;
        rd(3'd2, v); chk("R5 len0 empty idle", {31'b0, v[11]}, 1);
        bus_idle = 0;
        rd(3'd2, v); chk("R5 len0 busy", {31'b0, v[11]}, 0);
        bus_idle = 1;
        wr(3'd4, 32'd5);
        rd(3'd2, v); chk("R5 counted no eot", {31'b0, v[11]}, 0);
        pulse(0);
        rd(3'd2, v); chk("R5 counted eot", {31'b0, v[11]}, 1);
        wr(3'd3, 32'h8);
        rd(3'd2, v); chk("R5 counted cleared", {31'b0, v[11]}, 0);
        wr(3'd4, 32'd0);

        // R6 mode fault
        wr(3'd0, 32'h1);
        chk("R6 enabled", {31'b0, periph_en}, 1);
        pulse(6);
        chk("R6 fault clears enable", {31'b0, periph_en}, 0);
        wr(3'd0, 32'h3);
        chk("R6 blocked enable", {31'b0, periph_en}, 0);
        chk("R6 blocked lock", {31'b0, io_lock}, 0);
        wr(3'd3, 32'h200);
        wr(3'd0, 32'h1);
        chk("R6 enable after clear", {31'b0, periph_en}, 1);

        // R7 lock rules
        wr(3'd0, 32'h3);
        chk("R7 lock ignored while on", {31'b0, io_lock}, 0);
        wr(3'd0, 32'h0);
        wr(3'd0, 32'h2);
        chk("R7 lock set while off", {31'b0, io_lock}, 1);
        wr(3'd0, 32'h3);
        chk("R7 lock kept on enable", {31'b0, io_lock}, 1);
        wr(3'd0, 32'h0);
        chk("R7 lock drops on disable", {31'b0, io_lock}, 0);

        // R8 registered irq through the shared done enable
        txfifo_empty = 0;
        wr(3'd0, 32'h1);
        wr(3'd1, 32'h008);
        chk("R8 irq idle", {31'b0, irq}, 0);
        @(negedge clk); ev_set = 8'h80;
        @(negedge clk); ev_set = 0;
        chk("R8 irq one cycle late", {31'b0, irq}, 0);
        @(negedge clk);
        chk("R8 irq from suspend", {31'b0, irq}, 1);
        wr(3'd3, 32'h400);
        @(negedge clk);
        chk("R8 irq cleared", {31'b0, irq}, 0);

        // R9 disabled blocks all but mode fault
        wr(3'd1, 32'h240);
        wr(3'd0, 32'h0);
        pulse(3);
        @(negedge clk);
        chk("R9 overrun blocked", {31'b0, irq}, 0);
        pulse(6);
        @(negedge clk);
        chk("R9 fault passes", {31'b0, irq}, 1);
        wr(3'd3, 32'h7F8);

        // Random traffic compared against the model every cycle
        for (int i = 0; i < RAND_CYC; i++) begin
            @(negedge clk);
            reg_wr    = ($urandom_range(0, 3) == 0);
            reg_addr  = 3'($urandom_range(0, 7));
            reg_wdata = $urandom;
            if (reg_addr == 3'd4) reg_wdata[15:0] = 16'($urandom_range(0, 2));
            for (int k = 0; k < 8; k++) ev_set[k] = ($urandom_range(0, 15) == 0);
            rx_pkt_avail   = 1'($urandom);
            tx_space_avail = 1'($urandom);
            txfifo_empty   = 1'($urandom);
            bus_idle       = 1'($urandom);
            rx_level       = 2'($urandom);
            rx_word_full   = 1'($urandom);
        end
        @(negedge clk);
        reg_wr = 0; ev_set = 0;
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule